// File: doc/BRIEF.md
# Serial memory command decoder with block write protection

This block sits behind the pins of a serial memory slave. It watches the chip-select, serial clock and serial data inputs. It decodes each command, keeps the status byte, and returns that byte on the serial output when it is asked for. It also decides, byte by byte, whether a memory write may go through. The memory array itself sits outside the block. The block gives the array an address for reads and a one-cycle write grant, with address and data, for every byte it allows.

The serial pins are sampled on a fast system clock through synchronizers, and the edges of the serial clock are found from those samples. Both idle-low and idle-high serial clock polarities work. Input data is taken on the rising serial edge and output data is launched on the falling one. Write permission combines three things: the write-enable flag, an address-range lock chosen by two protect bits, and a hardware lock. The hardware lock freezes the protect configuration while the write-protect pin is low and the status write-disable bit is set.

Top module: `spi_sp_guard`

## Requirements
- R1: After reset the status byte reads 0x00, `so_oe` is 0 and `wr_grant` is 0.
- R2: Read-status (opcode 0x05) keeps `so_oe` low during the 8 opcode bits, then drives the status byte MSB first, one bit per falling serial edge. The layout is: write-disable flag at bit 7, protect bit PB1 at bit 3, protect bit PB0 at bit 2, write-enable flag at bit 1. Bits 6, 5, 4 and 0 always read 0.
- R3: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. Either takes effect when chip-select rises after the full opcode.
- R4: Write-status (opcode 0x01 followed by one data byte) loads bit 7 and bits 3:2 of the data byte, only when the write-enable flag is 1. It clears the write-enable flag when chip-select rises. With the flag at 0 it changes nothing.
- R5: When `wp_n` is low and the write-disable flag is 1, write-status leaves bits 7, 3 and 2 unchanged, but still clears the write-enable flag. When `wp_n` is high, write-status changes them whatever the write-disable flag holds. With `wp_n` low and the write-disable flag at 0, write-status also changes them.
- R6: Write (opcode 0x02, a 24-bit address MSB first of which the low 19 bits are used, then data bytes) handles each complete data byte the same way. If allowed, it pulses `wr_grant` for one cycle with `wr_addr` and `wr_data`. Either way the address then increments and wraps within 19 bits.
- R7: A byte is allowed only if the write-enable flag is 1 and its address is outside the locked range. The range is set by {PB1,PB0}: 00 locks nothing, 01 locks the top quarter, 10 the top half, 11 everything.
- R8: Chip-select rising after a write with at least one complete data byte clears the write-enable flag.
- R9: If chip-select rises before the opcode, the data byte of a write-status, or the first data byte of a write is complete, the status byte is unchanged and no grant is issued.
- R10: Read (opcode 0x03 plus a 24-bit address) presents the address on `mem_addr`. It shifts out `mem_rdata` MSB first and increments the address after each byte.
- R11: Commands work with the serial clock idling low and with it idling high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |
| mem_addr | output | 19 | Read address to the array |
| mem_rdata | input | 8 | Read data from the array for `mem_addr` |
| wr_grant | output | 1 | One-cycle strobe: write `wr_data` at `wr_addr` |
| wr_addr | output | 19 | Address of the granted byte |
| wr_data | output | 8 | Data of the granted byte |

## Verification
A wrong status value appears on the serial output at the next read-status, one falling serial edge per bit. A wrong lock or a wrong write-enable flag shows up a few system cycles after the eighth data bit of a write, as a missing or extra `wr_grant`. A command decoder that has lost track of the bit count shows up as shifted opcodes. These leave the status unchanged, or change it when they should not, and this is visible when chip-select rises. The bench covers every protect-bit setting at both edges of its locked range, write-status under each pin and flag combination, aborts at each phase, and both clock polarities.

// File: rtl/spi_sp_pkg.sv
package spi_sp_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  localparam int SR_LOCK = 7;
  localparam int SR_PB1  = 3;
  localparam int SR_PB0  = 2;
  localparam int SR_WEN  = 1;

  typedef enum logic [2:0] {
    CS_IDLE, CS_OPC, CS_ADDR, CS_WDATA, CS_SRDATA, CS_RDSR, CS_READ, CS_SKIP
  } cmd_st_t;

  typedef enum logic [1:0] {
    PD_NONE, PD_SET_WEN, PD_CLR_WEN, PD_WRSR
  } pend_t;
endpackage

// File: rtl/spi_sp_sync.sv
module spi_sp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_act,
  output logic si_s,
  output logic wp_n_s
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b0101;

  logic [STAGES-1:0][NPIN-1:0] chain_q, chain_n;
  logic [NPIN-1:0] last;
  logic            sck_d_q, cs_d_q;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], {sck, cs_n, si, wp_n}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{PIN_RST}};
      sck_d_q <= 1'b0;
      cs_d_q  <= 1'b1;
    end else begin
      chain_q <= chain_n;
      sck_d_q <= last[3];
      cs_d_q  <= last[2];
    end
  end

  assign last     = chain_q[STAGES-1];
  assign sck_rise = last[3] & ~sck_d_q;
  assign sck_fall = ~last[3] & sck_d_q;
  assign cs_fall  = ~last[2] & cs_d_q;
  assign cs_rise  = last[2] & ~cs_d_q;
  assign cs_act   = ~last[2];
  assign si_s     = last[1];
  assign wp_n_s   = last[0];
endmodule

// File: rtl/spi_sp_region.sv
module spi_sp_region #(
  parameter int ADDR_W = 19
) (
  input  logic [1:0]        pb,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  always_comb begin
    unique case (pb)
      2'b00:   locked = 1'b0;
      2'b01:   locked = &addr[ADDR_W-1 -: 2];
      2'b10:   locked = addr[ADDR_W-1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_sp_status.sv
module spi_sp_status
  import spi_sp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n_s,
  input  logic       set_wen,
  input  logic       clr_wen,
  input  logic       sr_wr,
  input  logic [7:0] sr_wdata,
  output logic       wen,
  output logic [1:0] pb,
  output logic [7:0] sr_byte
);
  logic       wen_q, wen_n, lock_q, lock_n;
  logic [1:0] pb_q, pb_n;
  logic       hw_lock, wr_ok;

  assign hw_lock = ~wp_n_s & lock_q;
  assign wr_ok   = sr_wr & wen_q & ~hw_lock;

  always_comb begin
    wen_n  = wen_q;
    lock_n = lock_q;
    pb_n   = pb_q;
    if (set_wen)      wen_n = 1'b1;
    else if (clr_wen) wen_n = 1'b0;
    if (wr_ok) begin
      lock_n = sr_wdata[SR_LOCK];
      pb_n   = {sr_wdata[SR_PB1], sr_wdata[SR_PB0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      lock_q <= 1'b0;
      pb_q   <= 2'b00;
    end else begin
      wen_q  <= wen_n;
      lock_q <= lock_n;
      pb_q   <= pb_n;
    end
  end

  always_comb begin
    sr_byte          = 8'h00;
    sr_byte[SR_LOCK] = lock_q;
    sr_byte[SR_PB1]  = pb_q[1];
    sr_byte[SR_PB0]  = pb_q[0];
    sr_byte[SR_WEN]  = wen_q;
  end

  assign wen = wen_q;
  assign pb  = pb_q;

  // R5
  hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> (pb_q == $past(pb_q) && lock_q == $past(lock_q)));

  // R4
  no_wen_no_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && !wen_q) |=> ($stable(pb_q) && $stable(lock_q)));
endmodule

// File: rtl/spi_sp_guard.sv
module spi_sp_guard
  import spi_sp_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int ADDR_FIELD  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wp_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              wr_grant,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int CNT_W = $clog2(ADDR_FIELD) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_FIELD - 1);

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, si_s, wp_n_s;
  logic wen, addr_locked, grant_locked;
  logic [1:0] pb;
  logic [7:0] sr_byte, byte_in, src_byte;
  logic set_wen, clr_wen, sr_wr;

  cmd_st_t state_q, state_n;
  pend_t   pend_q, pend_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [7:0]        sh_q, sh_n, sr_data_q, sr_data_n, out_q, out_n;
  logic [ADDR_W-1:0] addr_q, addr_n, gaddr_q, gaddr_n;
  logic [7:0]        gdata_q, gdata_n;
  logic [2:0]        oidx_q, oidx_n;
  logic is_wr_q, is_wr_n, so_q, so_n, oe_q, oe_n, grant_q, grant_n;

  spi_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_act(cs_act), .si_s(si_s), .wp_n_s(wp_n_s)
  );

  assign set_wen = cs_rise && (pend_q == PD_SET_WEN);
  assign clr_wen = cs_rise && (pend_q == PD_CLR_WEN || pend_q == PD_WRSR);
  assign sr_wr   = cs_rise && (pend_q == PD_WRSR);

  spi_sp_status u_status (
    .clk(clk), .rst_n(rst_n), .wp_n_s(wp_n_s), .set_wen(set_wen),
    .clr_wen(clr_wen), .sr_wr(sr_wr), .sr_wdata(sr_data_q),
    .wen(wen), .pb(pb), .sr_byte(sr_byte)
  );

  spi_sp_region #(.ADDR_W(ADDR_W)) u_region (
    .pb(pb), .addr(addr_q), .locked(addr_locked)
  );

  spi_sp_region #(.ADDR_W(ADDR_W)) u_chk_region (
    .pb(pb), .addr(gaddr_q), .locked(grant_locked)
  );

  assign byte_in  = {sh_q[6:0], si_s};
  assign src_byte = (state_q == CS_RDSR) ? sr_byte : mem_rdata;

  always_comb begin
    state_n   = state_q;
    pend_n    = pend_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    sr_data_n = sr_data_q;
    out_n     = out_q;
    addr_n    = addr_q;
    gaddr_n   = gaddr_q;
    gdata_n   = gdata_q;
    oidx_n    = oidx_q;
    is_wr_n   = is_wr_q;
    so_n      = so_q;
    oe_n      = oe_q;
    grant_n   = 1'b0;
    if (cs_fall) begin
      state_n = CS_OPC;
      cnt_n   = '0;
      pend_n  = PD_NONE;
      oe_n    = 1'b0;
    end else if (cs_rise) begin
      state_n = CS_IDLE;
      oe_n    = 1'b0;
    end else if (cs_act && sck_rise) begin
      sh_n  = byte_in;
      cnt_n = cnt_q + 1'b1;
      unique case (state_q)
        CS_OPC: begin
          if (cnt_q == LAST_BIT) begin
            cnt_n   = '0;
            state_n = CS_SKIP;
            case (byte_in)
              OP_WREN:  pend_n = PD_SET_WEN;
              OP_WRDI:  pend_n = PD_CLR_WEN;
              OP_WRSR:  state_n = CS_SRDATA;
              OP_RDSR: begin
                state_n = CS_RDSR;
                oe_n    = 1'b1;
                oidx_n  = 3'd0;
              end
              OP_READ: begin
                state_n = CS_ADDR;
                is_wr_n = 1'b0;
              end
              OP_WRITE: begin
                state_n = CS_ADDR;
                is_wr_n = 1'b1;
              end
              default: state_n = CS_SKIP;
            endcase
          end
        end
        CS_SRDATA: begin
          if (cnt_q == LAST_BIT) begin
            sr_data_n = byte_in;
            pend_n    = PD_WRSR;
            state_n   = CS_SKIP;
          end
        end
        CS_ADDR: begin
          addr_n = {addr_q[ADDR_W-2:0], si_s};
          if (cnt_q == LAST_ADDR) begin
            cnt_n = '0;
            if (is_wr_q) begin
              state_n = CS_WDATA;
            end else begin
              state_n = CS_READ;
              oe_n    = 1'b1;
              oidx_n  = 3'd0;
            end
          end
        end
        CS_WDATA: begin
          if (cnt_q == LAST_BIT) begin
            cnt_n  = '0;
            pend_n = PD_CLR_WEN;
            addr_n = addr_q + 1'b1;
            if (wen && !addr_locked) begin
              grant_n = 1'b1;
              gaddr_n = addr_q;
              gdata_n = byte_in;
            end
          end
        end
        default: ;
      endcase
    end else if (cs_act && sck_fall && (state_q == CS_RDSR || state_q == CS_READ)) begin
      if (oidx_q == 3'd0) begin
        so_n  = src_byte[7];
        out_n = {src_byte[6:0], 1'b0};
      end else begin
        so_n  = out_q[7];
        out_n = {out_q[6:0], 1'b0};
      end
      oidx_n = oidx_q + 3'd1;
      if (state_q == CS_READ && oidx_q == 3'd7) addr_n = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CS_IDLE;
      pend_q    <= PD_NONE;
      cnt_q     <= '0;
      sh_q      <= '0;
      sr_data_q <= '0;
      out_q     <= '0;
      addr_q    <= '0;
      gaddr_q   <= '0;
      gdata_q   <= '0;
      oidx_q    <= '0;
      is_wr_q   <= 1'b0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
      grant_q   <= 1'b0;
    end else begin
      state_q   <= state_n;
      pend_q    <= pend_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      sr_data_q <= sr_data_n;
      out_q     <= out_n;
      addr_q    <= addr_n;
      gaddr_q   <= gaddr_n;
      gdata_q   <= gdata_n;
      oidx_q    <= oidx_n;
      is_wr_q   <= is_wr_n;
      so_q      <= so_n;
      oe_q      <= oe_n;
      grant_q   <= grant_n;
    end
  end

  assign so       = so_q;
  assign so_oe    = oe_q;
  assign mem_addr = addr_q;
  assign wr_grant = grant_q;
  assign wr_addr  = gaddr_q;
  assign wr_data  = gdata_q;

  // R2
  opc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_OPC) |-> !so_oe);

  // R7
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> (wen && !grant_locked));

  // R6
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |=> !wr_grant);

  // R9
  abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && pend_q == PD_NONE) |=> $stable(sr_byte));
endmodule

// File: tb/spi_sp_guard_bench.sv
`timescale 1ns/1ps
module spi_sp_guard_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, wp_n;
  logic so, so_oe, wr_grant;
  logic [18:0] mem_addr, wr_addr;
  logic [7:0]  mem_rdata, wr_data;
  logic mode3;

  int n_chk = 0;
  int n_fail = 0;
  int grant_cnt = 0;
  logic [18:0] last_ga;
  logic [7:0]  last_gd;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  spi_sp_guard u_spi_sp_guard (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_grant(wr_grant), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_grant) begin
      grant_cnt = grant_cnt + 1;
      last_ga   = wr_addr;
      last_gd   = wr_data;
    end
  end

  // {pb[1:0], address[18:0], grant expected}
  localparam logic [21:0] VEC [8] = '{
    {2'b00, 19'h7FFFF, 1'b1},
    {2'b01, 19'h5FFFF, 1'b1},
    {2'b01, 19'h60000, 1'b0},
    {2'b10, 19'h3FFFF, 1'b1},
    {2'b10, 19'h40000, 1'b0},
    {2'b11, 19'h00000, 1'b0},
    {2'b00, 19'h00000, 1'b1},
    {2'b01, 19'h7FFFF, 1'b0}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    sck = mode3;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    sck = mode3;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int nb,
                            output logic [7:0] rx, output logic oe_seen);
    rx = 8'h00;
    oe_seen = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0;
      si  = tx[i];
      wait_clk(HALF);
      rx[i]   = so;
      oe_seen = oe_seen | so_oe;
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic send_op(input logic [7:0] op);
    logic [7:0] rx;
    logic oe;
    cs_begin();
    shift_bits(op, 8, rx, oe);
    cs_end();
  endtask

  task automatic read_sr(output logic [7:0] v, output logic oe_op);
    logic oe;
    logic [7:0] rx;
    cs_begin();
    shift_bits(8'h05, 8, rx, oe_op);
    shift_bits(8'h00, 8, v, oe);
    cs_end();
  endtask

  task automatic write_sr(input logic [7:0] d);
    logic [7:0] rx;
    logic oe;
    cs_begin();
    shift_bits(8'h01, 8, rx, oe);
    shift_bits(d, 8, rx, oe);
    cs_end();
  endtask

  task automatic send_addr(input logic [7:0] op, input logic [18:0] a);
    logic [7:0] rx;
    logic oe;
    logic [23:0] f;
    f = {5'b0, a};
    shift_bits(op, 8, rx, oe);
    shift_bits(f[23:16], 8, rx, oe);
    shift_bits(f[15:8], 8, rx, oe);
    shift_bits(f[7:0], 8, rx, oe);
  endtask

  task automatic write1(input logic [18:0] a, input logic [7:0] d);
    logic [7:0] rx;
    logic oe;
    cs_begin();
    send_addr(8'h02, a);
    shift_bits(d, 8, rx, oe);
    cs_end();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, rx;
    logic oe;
    int g0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; wp_n = 1'b1; mode3 = 1'b0;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check("R1 so_oe", {31'b0, so_oe}, 32'd0);
    check("R1 wr_grant", {31'b0, wr_grant}, 32'd0);
    read_sr(v, oe);
    check("R1 status", {24'b0, v}, 32'h00);
    // R2 output quiet during opcode
    check("R2 opcode hi-z", {31'b0, oe}, 32'd0);

    // R3 set and clear write-enable
    send_op(8'h06);
    read_sr(v, oe);
    check("R3 wren", {24'b0, v}, 32'h02);
    send_op(8'h04);
    read_sr(v, oe);
    check("R3 wrdi", {24'b0, v}, 32'h00);

    // R4 write-status ignored with write-enable clear
    write_sr(8'h8C);
    read_sr(v, oe);
    check("R4 no wen", {24'b0, v}, 32'h00);
    // R4 / R2 write with enable, unmodelled bits read 0
    send_op(8'h06);
    write_sr(8'hFD);
    read_sr(v, oe);
    check("R4 wrsr layout", {24'b0, v}, 32'h8C);

    // R5 hardware lock
    wp_n = 1'b0;
    wait_clk(8);
    send_op(8'h06);
    read_sr(v, oe);
    check("R5 wen under lock", {24'b0, v}, 32'h8E);
    write_sr(8'h00);
    read_sr(v, oe);
    check("R5 frozen", {24'b0, v}, 32'h8C);
    send_op(8'h06);
    g0 = grant_cnt;
    write1(19'h00000, 8'h55);
    check("R7 all locked", grant_cnt - g0, 32'd0);
    read_sr(v, oe);
    check("R8 wen cleared", {24'b0, v}, 32'h8C);
    // R5 software mode with pin high
    wp_n = 1'b1;
    wait_clk(8);
    send_op(8'h06);
    write_sr(8'h00);
    read_sr(v, oe);
    check("R5 sw mode", {24'b0, v}, 32'h00);
    // R5 pin low but write-disable clear
    wp_n = 1'b0;
    wait_clk(8);
    send_op(8'h06);
    write_sr(8'h04);
    read_sr(v, oe);
    check("R5 pin low unlocked", {24'b0, v}, 32'h04);
    send_op(8'h06);
    write_sr(8'h00);
    wp_n = 1'b1;
    wait_clk(8);

    // R6 / R7 table of lock ranges
    for (int k = 0; k < 8; k++) begin
      logic [1:0]  pbk;
      logic [18:0] ak;
      logic        ek;
      pbk = VEC[k][21:20];
      ak  = VEC[k][19:1];
      ek  = VEC[k][0];
      send_op(8'h06);
      write_sr({4'b0, pbk, 2'b00});
      send_op(8'h06);
      g0 = grant_cnt;
      write1(ak, 8'h30 + 8'(k));
      check("R7 grant count", grant_cnt - g0, {31'b0, ek});
      if (ek) begin
        check("R6 grant addr", {13'b0, last_ga}, {13'b0, ak});
        check("R6 grant data", {24'b0, last_gd}, {24'b0, 8'h30 + 8'(k)});
      end
      read_sr(v, oe);
      check("R8 after write", {24'b0, v}, {28'b0, pbk, 2'b00});
    end

    // R6 multi-byte with address wrap
    send_op(8'h06);
    write_sr(8'h00);
    send_op(8'h06);
    g0 = grant_cnt;
    cs_begin();
    send_addr(8'h02, 19'h7FFFF);
    shift_bits(8'h11, 8, rx, oe);
    wait_clk(HALF);
    check("R6 first addr", {13'b0, last_ga}, 32'h7FFFF);
    shift_bits(8'h22, 8, rx, oe);
    cs_end();
    check("R6 two grants", grant_cnt - g0, 32'd2);
    check("R6 wrap addr", {13'b0, last_ga}, 32'h00000);
    check("R6 second data", {24'b0, last_gd}, 32'h22);
    read_sr(v, oe);
    check("R8 multi", {24'b0, v}, 32'h00);

    // R9 aborts
    send_op(8'h06);
    cs_begin();
    shift_bits(8'h04, 5, rx, oe);
    cs_end();
    read_sr(v, oe);
    check("R9 partial opcode", {24'b0, v}, 32'h02);
    cs_begin();
    shift_bits(8'h01, 8, rx, oe);
    shift_bits(8'hFF, 4, rx, oe);
    cs_end();
    read_sr(v, oe);
    check("R9 partial wrsr", {24'b0, v}, 32'h02);
    g0 = grant_cnt;
    cs_begin();
    send_addr(8'h02, 19'h00123);
    shift_bits(8'hAA, 4, rx, oe);
    cs_end();
    check("R9 partial write grant", grant_cnt - g0, 32'd0);
    read_sr(v, oe);
    check("R9 partial write wen", {24'b0, v}, 32'h02);

    // R10 read path
    cs_begin();
    send_addr(8'h03, 19'h00010);
    shift_bits(8'h00, 8, rx, oe);
    check("R10 byte0", {24'b0, rx}, 32'hB5);
    check("R10 oe", {31'b0, oe}, 32'd1);
    shift_bits(8'h00, 8, rx, oe);
    check("R10 byte1", {24'b0, rx}, 32'hB4);
    cs_end();

    // R11 idle-high clock
    mode3 = 1'b1;
    sck = 1'b1;
    wait_clk(8);
    read_sr(v, oe);
    check("R11 rdsr mode3", {24'b0, v}, 32'h02);
    g0 = grant_cnt;
    write1(19'h00100, 8'h77);
    check("R11 grant mode3", grant_cnt - g0, 32'd1);
    check("R11 data mode3", {24'b0, last_gd}, 32'h77);
    send_op(8'h06);
    send_op(8'h04);
    read_sr(v, oe);
    check("R11 wrdi mode3", {24'b0, v}, 32'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule